// File: doc/BRIEF.md
# ADC Select-Mode Conversion Sequencer

This block sequences a successive-approximation analog-to-digital converter that repeatedly converts one chosen input channel. A mode register, loaded through a one-cycle write strobe, holds a run bit, a select-mode bit, a 3-bit channel number, a clock-range bit and a trigger-enable bit. While the run and select-mode bits are both set, the block keeps the channel multiplexer pointed at the chosen input. It holds the sample window open, then walks eight bit decisions from the most significant bit down. For each decision it presents a trial code to an external comparator and reads back a single digital comparator bit.

Each completed conversion is latched into the result register. When trigger mode is enabled, each completion also raises a one-clock interrupt pulse. In trigger mode, a rising edge on the external trigger input throws away the conversion in progress and starts a new one from its sample window. Any write to the mode register likewise restarts the sequence. Clearing the run bit stops the block at once.

Top module: `adc_sel_seq`

## Requirements
- R1: With the clock-range bit at 0, a conversion lasts 180 clocks: the result register takes its new value at the 180th rising edge after the mode-write edge, and again every 180 edges after that.
- R2: With the clock-range bit at 1, a conversion lasts 120 clocks, so results land 120 edges after the write edge and every 120 edges after that.
- R3: `sample_en` is high for the first 36 clocks of each conversion when the clock-range bit is 0, and for the first 24 when it is 1. It is low for the rest of the conversion.
- R4: `mux_sel` equals the written channel number. Every result is the code of that channel, as decided bit by bit through `cmp_in` (1 means the input is at or above `dac_code`).
- R5: After sampling, each of the 8 bit decisions lasts (total − sampling)/8 clocks, which is 18 or 12. Decisions run from bit 7 down to bit 0. During a decision, `dac_code` shows the bits already decided plus the trial bit, and it is 0 during sampling.
- R6: `eoc_irq` is a one-clock pulse in the same cycle the new result first appears. It occurs only when the trigger-enable bit is 1.
- R7: With trigger enable at 1, a rising trigger edge restarts the conversion. The next result lands 180 or 120 edges after the edge that saw the trigger, and the interrupted conversion writes no result.
- R8: With trigger enable at 0, trigger edges have no effect and conversions keep their schedule.
- R9: Writing the run bit to 0 makes the block idle from the next cycle: `sample_en` low, `dac_code` 0, no interrupt, and the result unchanged. A stop written on a completion edge cancels that completion.
- R10: A mode write during a conversion aborts it without touching the result register. A new conversion on the newly written channel starts at the write edge.
- R11: With the select-mode bit at 0, no conversion runs, even when the run bit is set.
- R12: After reset, `result`, `eoc_irq`, `sample_en`, `dac_code` and `mux_sel` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | One-cycle strobe that loads the mode register |
| wr_start | input | 1 | Run bit to load |
| wr_select | input | 1 | Select-mode bit to load |
| wr_chan | input | 3 | Channel number to load |
| wr_fast | input | 1 | Clock-range bit to load (1 selects the 120-clock timing) |
| wr_trig_en | input | 1 | Trigger-enable bit to load |
| trig_in | input | 1 | External trigger; rising edge is used |
| cmp_in | input | 1 | Comparator decision: input at or above `dac_code` |
| mux_sel | output | 3 | Analog multiplexer channel select |
| sample_en | output | 1 | Sample window active |
| dac_code | output | 8 | Trial code for the comparator |
| result | output | 8 | Last completed conversion |
| eoc_irq | output | 1 | End-of-conversion interrupt pulse |

## Verification
Every result is due a fixed number of edges after its cause. A mode write or an accepted trigger edge at edge E puts the new code on `result`, with `eoc_irq` high, in the cycle after edge E+180 or E+120. The sample-window boundary and each bit decision fall at fixed offsets from E as well. The bench counts rising edges and queues each expected result under its exact due edge, and a monitor compares at the falling edge of that cycle. Any interrupt pulse outside a queued cycle is reported, and aborted conversions are checked by queuing the old value at the edge where the cancelled result would have appeared.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned CHAN_W = 3;
  localparam int unsigned DATA_W = 8;

  typedef enum logic {
    PH_SAMPLE = 1'b0,
    PH_BITS   = 1'b1
  } phase_e;
endpackage

// File: rtl/adc_trig_edge.sv
module adc_trig_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic rise
);
  logic trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_in;
  end

  assign rise = trig_in & ~trig_q;

  // R7: a detected edge lasts a single cycle
  p_edge_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/adc_seq_timer.sv
module adc_seq_timer
  import adc_seq_pkg::*;
#(
  parameter int unsigned TOTAL_SLOW = 180,
  parameter int unsigned SAMP_SLOW  = 36,
  parameter int unsigned TOTAL_FAST = 120,
  parameter int unsigned SAMP_FAST  = 24,
  parameter int unsigned NBITS      = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  input  logic                       restart,
  input  logic                       fast,
  output phase_e                     phase,
  output logic [$clog2(NBITS)-1:0]   bit_idx,
  output logic                       decide,
  output logic                       done
);
  localparam int unsigned BIT_SLOW = (TOTAL_SLOW - SAMP_SLOW) / NBITS;
  localparam int unsigned BIT_FAST = (TOTAL_FAST - SAMP_FAST) / NBITS;
  localparam int unsigned CNT_W    = $clog2(TOTAL_SLOW + 1);
  localparam int unsigned IDX_W    = $clog2(NBITS);
  localparam logic [CNT_W-1:0] SAMP_LAST_S = CNT_W'(SAMP_SLOW - 1);
  localparam logic [CNT_W-1:0] SAMP_LAST_F = CNT_W'(SAMP_FAST - 1);
  localparam logic [CNT_W-1:0] SLOT_LAST_S = CNT_W'(BIT_SLOW - 1);
  localparam logic [CNT_W-1:0] SLOT_LAST_F = CNT_W'(BIT_FAST - 1);
  localparam logic [IDX_W-1:0] IDX_TOP     = IDX_W'(NBITS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  phase_e           ph_q, ph_d;
  logic [CNT_W-1:0] samp_last, slot_last;
  logic             cnt_en;

  assign samp_last = fast ? SAMP_LAST_F : SAMP_LAST_S;
  assign slot_last = fast ? SLOT_LAST_F : SLOT_LAST_S;
  assign cnt_en    = run | restart | (ph_q != PH_SAMPLE) | (cnt_q != '0);

  always_comb begin
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    ph_d   = ph_q;
    decide = 1'b0;
    done   = 1'b0;
    if (!run || restart) begin
      cnt_d = '0;
      idx_d = IDX_TOP;
      ph_d  = PH_SAMPLE;
    end else if (ph_q == PH_SAMPLE) begin
      if (cnt_q == samp_last) begin
        cnt_d = '0;
        idx_d = IDX_TOP;
        ph_d  = PH_BITS;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q == slot_last) begin
        decide = 1'b1;
        cnt_d  = '0;
        if (idx_q == '0) begin
          done  = 1'b1;
          idx_d = IDX_TOP;
          ph_d  = PH_SAMPLE;
        end else begin
          idx_d = idx_q - 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx_q <= IDX_TOP;
      ph_q  <= PH_SAMPLE;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      ph_q  <= ph_d;
    end
  end

  assign phase   = ph_q;
  assign bit_idx = idx_q;

  // R3: the sample window never runs past its mode's length
  p_samp_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SAMPLE) |-> (cnt_q <= samp_last));
  // R5: each bit slot never runs past its mode's length
  p_slot_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_BITS) |-> (cnt_q <= slot_last));
  // R7: a restart always lands at the start of the sample window
  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && restart) |=> (ph_q == PH_SAMPLE && cnt_q == '0));
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  phase_e            phase,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              decide,
  input  logic              done,
  input  logic              cmp_in,
  input  logic              irq_en,
  output logic [DATA_W-1:0] dac_code,
  output logic [DATA_W-1:0] result,
  output logic              irq
);
  logic [DATA_W-1:0] sar_q, sar_d, sar_set, onehot;
  logic [DATA_W-1:0] res_q, res_d;
  logic              irq_q, irq_d;
  logic              sar_en, res_en;

  assign onehot = {{(DATA_W-1){1'b0}}, 1'b1} << bit_idx;

  always_comb begin
    sar_set          = sar_q;
    sar_set[bit_idx] = cmp_in;
  end

  always_comb begin
    sar_en = clear | decide;
    sar_d  = sar_q;
    if (clear || done) sar_d = '0;
    else if (decide)   sar_d = sar_set;
  end

  always_comb begin
    res_en = done & ~clear;
    res_d  = sar_set;
    irq_d  = done & ~clear & irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q <= '0;
    end else if (sar_en) begin
      sar_q <= sar_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign dac_code = (phase == PH_BITS) ? (sar_q | onehot) : '0;
  assign result   = res_q;
  assign irq      = irq_q;

  // R6: the interrupt never lasts two cycles
  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);
  // R10: the result moves only right after a completed conversion
  p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_q != $past(res_q)) |-> $past(done));
endmodule

// File: rtl/adc_sel_seq.sv
module adc_sel_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned TOTAL_SLOW = 180,
  parameter int unsigned SAMP_SLOW  = 36,
  parameter int unsigned TOTAL_FAST = 120,
  parameter int unsigned SAMP_FAST  = 24,
  parameter int unsigned CH_W       = adc_seq_pkg::CHAN_W,
  parameter int unsigned RES_W      = adc_seq_pkg::DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_wr,
  input  logic             wr_start,
  input  logic             wr_select,
  input  logic [CH_W-1:0]  wr_chan,
  input  logic             wr_fast,
  input  logic             wr_trig_en,
  input  logic             trig_in,
  input  logic             cmp_in,
  output logic [CH_W-1:0]  mux_sel,
  output logic             sample_en,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result,
  output logic             eoc_irq
);
  localparam int unsigned IDX_W = $clog2(RES_W);

  logic            start_q, sel_q, fast_q, trg_q;
  logic [CH_W-1:0] chan_q;
  logic            run, restart, clear, trig_rise;
  phase_e          phase;
  logic [IDX_W-1:0] bit_idx;
  logic            decide, done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      sel_q   <= 1'b0;
      chan_q  <= '0;
      fast_q  <= 1'b0;
      trg_q   <= 1'b0;
    end else if (mode_wr) begin
      start_q <= wr_start;
      sel_q   <= wr_select;
      chan_q  <= wr_chan;
      fast_q  <= wr_fast;
      trg_q   <= wr_trig_en;
    end
  end

  adc_trig_edge u_trig (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_in (trig_in),
    .rise    (trig_rise)
  );

  assign run     = start_q & sel_q;
  assign restart = mode_wr | (trig_rise & trg_q & run);
  assign clear   = ~run | restart;

  adc_seq_timer #(
    .TOTAL_SLOW (TOTAL_SLOW),
    .SAMP_SLOW  (SAMP_SLOW),
    .TOTAL_FAST (TOTAL_FAST),
    .SAMP_FAST  (SAMP_FAST),
    .NBITS      (RES_W)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (restart),
    .fast    (fast_q),
    .phase   (phase),
    .bit_idx (bit_idx),
    .decide  (decide),
    .done    (done)
  );

  adc_sar_core #(
    .DATA_W (RES_W),
    .IDX_W  (IDX_W)
  ) u_sar (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .phase    (phase),
    .bit_idx  (bit_idx),
    .decide   (decide),
    .done     (done),
    .cmp_in   (cmp_in),
    .irq_en   (trg_q),
    .dac_code (dac_code),
    .result   (result),
    .irq      (eoc_irq)
  );

  assign mux_sel   = chan_q;
  assign sample_en = run & (phase == PH_SAMPLE);

  // R9: a stopped block is silent
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!sample_en && dac_code == '0 && !eoc_irq));
  // R6: interrupts come only with trigger mode enabled
  p_irq_trig_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq |-> trg_q);
  // R11: select-mode bit clear means no activity
  p_select_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |-> (!sample_en && !eoc_irq));
endmodule

// File: tb/adc_sel_seq_tb.sv
module adc_sel_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef struct {
    int         due;
    logic [7:0] val;
    logic       irq;
    string      req;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr = 1'b0, wr_start = 1'b0, wr_select = 1'b0;
  logic [2:0] wr_chan = '0;
  logic       wr_fast = 1'b0, wr_trig_en = 1'b0, trig_in = 1'b0;
  logic       cmp_in;
  logic [2:0] mux_sel;
  logic       sample_en;
  logic [7:0] dac_code, result;
  logic       eoc_irq;

  logic [7:0] ain [8];
  exp_t       sbq [$];
  int         cyc = 0;
  int         tests = 0;
  int         fails = 0;
  logic       mon_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign cmp_in = (ain[mux_sel] >= dac_code);

  adc_sel_seq dut_i (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .wr_start(wr_start),
    .wr_select(wr_select), .wr_chan(wr_chan), .wr_fast(wr_fast),
    .wr_trig_en(wr_trig_en), .trig_in(trig_in), .cmp_in(cmp_in),
    .mux_sel(mux_sel), .sample_en(sample_en), .dac_code(dac_code),
    .result(result), .eoc_irq(eoc_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: got %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic push(input int due, input logic [7:0] val, input logic irq, input string req);
    exp_t e;
    e.due = due; e.val = val; e.irq = irq; e.req = req;
    sbq.push_back(e);
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic wr_mode(input logic st, input logic sl, input logic [2:0] ch,
                         input logic fs, input logic tg, output int ew);
    mode_wr = 1'b1; wr_start = st; wr_select = sl; wr_chan = ch;
    wr_fast = fs; wr_trig_en = tg;
    ew = cyc + 1;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_on) begin
      if (sbq.size() > 0 && sbq[0].due < cyc) begin
        tests++; fails++;
        $display("FAIL %s: item due at %0d missed, got %0h expected %0h",
                 sbq[0].req, sbq[0].due, result, sbq[0].val);
        void'(sbq.pop_front());
      end
      if (sbq.size() > 0 && sbq[0].due == cyc) begin
        chk(sbq[0].req, {24'd0, result}, {24'd0, sbq[0].val});
        chk(sbq[0].req, {31'd0, eoc_irq}, {31'd0, sbq[0].irq});
        void'(sbq.pop_front());
      end else if (eoc_irq) begin
        tests++; fails++;
        $display("FAIL R6 at cycle %0d: got irq 1 expected 0", cyc);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog at cycle %0d: got timeout expected finish", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int ew, ew2, ew3, et;
    for (int i = 0; i < 8; i++) ain[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12", {24'd0, result}, 32'h0);
    chk("R12", {31'd0, eoc_irq}, 32'h0);
    chk("R12", {31'd0, sample_en}, 32'h0);
    chk("R12", {24'd0, dac_code}, 32'h0);
    chk("R12", {29'd0, mux_sel}, 32'h0);
    mon_on = 1'b1;

    // R1 slow timing, R3, R4, R5, R6 with trigger mode on
    ain[3] = 8'hA5;
    wr_mode(1'b1, 1'b1, 3'd3, 1'b0, 1'b1, ew);
    chk("R4", {29'd0, mux_sel}, 32'd3);
    chk("R3", {31'd0, sample_en}, 32'd1);
    push(ew + 179, 8'h00, 1'b0, "R1");
    push(ew + 180, 8'hA5, 1'b1, "R1");
    push(ew + 360, 8'hA5, 1'b1, "R1");
    wait_to(ew + 35); chk("R3", {31'd0, sample_en}, 32'd1);
    wait_to(ew + 36); chk("R3", {31'd0, sample_en}, 32'd0);
    chk("R5", {24'd0, dac_code}, 32'h80);
    wait_to(ew + 53); chk("R5", {24'd0, dac_code}, 32'h80);
    wait_to(ew + 54); chk("R5", {24'd0, dac_code}, 32'hC0);
    wait_to(ew + 361);

    // R2 fast timing, R6 no irq with trigger mode off
    ain[6] = 8'hFF;
    wr_mode(1'b1, 1'b1, 3'd6, 1'b1, 1'b0, ew);
    chk("R4", {29'd0, mux_sel}, 32'd6);
    push(ew + 119, 8'hA5, 1'b0, "R2");
    push(ew + 120, 8'hFF, 1'b0, "R2");
    wait_to(ew + 23); chk("R3", {31'd0, sample_en}, 32'd1);
    wait_to(ew + 24); chk("R3", {31'd0, sample_en}, 32'd0);
    chk("R5", {24'd0, dac_code}, 32'h80);
    wait_to(ew + 36); chk("R5", {24'd0, dac_code}, 32'hC0);
    wait_to(ew + 121);

    // R7 trigger restart
    ain[1] = 8'h5A;
    wr_mode(1'b1, 1'b1, 3'd1, 1'b0, 1'b1, ew);
    wait_to(ew + 99);
    trig_in = 1'b1; et = ew + 100;
    @(negedge clk); trig_in = 1'b0;
    push(ew + 180, 8'hFF, 1'b0, "R7");
    push(et + 180, 8'h5A, 1'b1, "R7");
    wait_to(et + 181);

    // R8 trigger ignored
    ain[2] = 8'h11;
    wr_mode(1'b1, 1'b1, 3'd2, 1'b1, 1'b0, ew);
    wait_to(ew + 49);
    trig_in = 1'b1;
    @(negedge clk); trig_in = 1'b0;
    push(ew + 119, 8'h5A, 1'b0, "R8");
    push(ew + 120, 8'h11, 1'b0, "R8");
    wait_to(ew + 121);

    // R10 mode write aborts
    ain[5] = 8'h77; ain[0] = 8'h01;
    wr_mode(1'b1, 1'b1, 3'd5, 1'b1, 1'b1, ew);
    wait_to(ew + 59);
    wr_mode(1'b1, 1'b1, 3'd0, 1'b1, 1'b1, ew2);
    push(ew + 120, 8'h11, 1'b0, "R10");
    push(ew2 + 120, 8'h01, 1'b1, "R10");
    wait_to(ew2 + 121);

    // R9 stop written on a completion edge
    ain[0] = 8'h02;
    wait_to(ew2 + 239);
    push(ew2 + 240, 8'h01, 1'b0, "R9");
    wr_mode(1'b0, 1'b1, 3'd0, 1'b1, 1'b1, ew3);
    chk("R9", {31'd0, sample_en}, 32'd0);
    chk("R9", {24'd0, dac_code}, 32'h0);
    wait_to(ew3 + 200);
    chk("R9", {31'd0, sample_en}, 32'd0);
    chk("R9", {24'd0, result}, 32'h01);

    // R11 select-mode bit clear
    ain[0] = 8'h33;
    wr_mode(1'b1, 1'b0, 3'd0, 1'b0, 1'b1, ew);
    wait_to(ew + 10);
    chk("R11", {31'd0, sample_en}, 32'd0);
    chk("R11", {24'd0, dac_code}, 32'h0);
    push(ew + 180, 8'h01, 1'b0, "R11");
    wait_to(ew + 200);

    if (sbq.size() != 0) begin
      tests++; fails++;
      $display("FAIL scoreboard: got %0d pending items expected 0", sbq.size());
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule